// File: doc/BRIEF.md
# Parallel I/O Port Register Block

This block is one general-purpose parallel I/O port of up to 32 pins, controlled through a small word-addressed register bus. Software writes a direction word and an output word, and reads back the sampled pad levels. For each pin the block drives an output value and an output-enable. It also takes in the pad level, passed through a synchronizer.

Besides a plain output-word register, three write-only alias offsets set, clear or invert chosen output bits in a single write. A 1 in the write data selects a bit and a 0 leaves it alone. Software therefore never needs a read-modify-write sequence to change a few pins.

The bus has no back-pressure. It accepts a write or a read on every cycle. A read returns its data on `rd_data` one clock after `rd_en`, and `rd_data` then holds until the next read. Writes take effect at the clock edge where `wr_en` is sampled high.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the output latch and the direction word are all zero, every `pin_oe` bit is 0 and `rd_data` is 0.
- R2: A write to offset 0x14 sets the direction word. A direction bit of 1 drives `pin_oe` high for that pin, making it an output. A bit of 0 makes the pin an input with its driver off. A read of 0x14 returns the direction word.
- R3: A write to offset 0x00 replaces every output latch bit at once. A read of 0x00 returns the latch. The latch changes only through a mapped write.
- R4: A write to offset 0x04 sets each latch bit whose write-data bit is 1 and leaves the other bits as they were.
- R5: A write to offset 0x08 clears each latch bit whose write-data bit is 1 and leaves the other bits as they were.
- R6: A write to offset 0x0C inverts each latch bit whose write-data bit is 1 and leaves the other bits as they were.
- R7: Reads of offsets 0x04, 0x08 and 0x0C return 0.
- R8: A read of offset 0x10 returns the level of every pin, whether input or output, after a two-flop synchronizer. A pad change is seen by a read issued on the third clock after the change, and not by a read issued on the second.
- R9: Bit positions at or above NUM_PINS have no storage. They read as 0 in every register, and writes to them are dropped.
- R10: A write to any other address, including a misaligned one, changes nothing. A read of such an address returns 0.
- R11: Writing the output value of a pin configured as an input leaves that pin undriven (`pin_oe` stays 0). The latched value shows on the pad only once the direction bit is set.
- R12: `rd_data` updates one clock after `rd_en` and holds between reads. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte offset from the port base |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 32 | Read data, valid one clock after `rd_en` |
| pin_in | input | NUM_PINS | Pad levels (asynchronous) |
| pin_out | output | NUM_PINS | Output latch value per pin |
| pin_oe | output | NUM_PINS | Output driver enable per pin |

## Verification
The bench builds the block with NUM_PINS = 20, which leaves twelve register bits with no pin behind them. This makes the zero readback and the dropped writes of R9 visible through every register. The pads are looped back so that output pins return their own latch value and input pins return a level driven by the bench. The synchronizer depth of 2 and ADDR_W of 8 stay at their defaults, so the exact read-latency boundary and misaligned or out-of-map offsets can both be exercised.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned BUS_W = 32;

  localparam logic [7:0] OFS_DOUT = 8'h00;
  localparam logic [7:0] OFS_SET  = 8'h04;
  localparam logic [7:0] OFS_CLR  = 8'h08;
  localparam logic [7:0] OFS_TOG  = 8'h0C;
  localparam logic [7:0] OFS_DIN  = 8'h10;
  localparam logic [7:0] OFS_DIR  = 8'h14;

  typedef enum logic [2:0] {
    SEL_DOUT = 3'd0,
    SEL_SET  = 3'd1,
    SEL_CLR  = 3'd2,
    SEL_TOG  = 3'd3,
    SEL_DIN  = 3'd4,
    SEL_DIR  = 3'd5,
    SEL_NONE = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic dout;
    logic set;
    logic clr;
    logic tog;
    logic dir;
  } wr_strobe_t;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output reg_sel_e          sel,
  output wr_strobe_t        wstb
);

  always_comb begin
    sel = SEL_NONE;
    if (ADDR_W <= 8 || addr[ADDR_W-1:0] < ADDR_W'(256)) begin
      unique case (8'(addr))
        OFS_DOUT: sel = SEL_DOUT;
        OFS_SET:  sel = SEL_SET;
        OFS_CLR:  sel = SEL_CLR;
        OFS_TOG:  sel = SEL_TOG;
        OFS_DIN:  sel = SEL_DIN;
        OFS_DIR:  sel = SEL_DIR;
        default:  sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    wstb      = '0;
    wstb.dout = wr_en && (sel == SEL_DOUT);
    wstb.set  = wr_en && (sel == SEL_SET);
    wstb.clr  = wr_en && (sel == SEL_CLR);
    wstb.tog  = wr_en && (sel == SEL_TOG);
    wstb.dir  = wr_en && (sel == SEL_DIR);
  end

  // R10: at most one register is written per cycle, none without a strobe
  p_single_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wstb) && (!wr_en -> (wstb == '0)));

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wr_strobe_t          wstb,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] lat_q,
  output logic [NUM_PINS-1:0] dir_q
);

  logic [NUM_PINS-1:0] lat_d;

  always_comb begin
    lat_d = lat_q;
    if (wstb.dout) lat_d = wdata;
    if (wstb.set)  lat_d = lat_q | wdata;
    if (wstb.clr)  lat_d = lat_q & ~wdata;
    if (wstb.tog)  lat_d = lat_q ^ wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
    end else begin
      lat_q <= lat_d;
      if (wstb.dir) dir_q <= wdata;
    end
  end

  p_set_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.set |=> ((lat_q & $past(wdata)) == $past(wdata)) &&
                 ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata))));

  p_clr_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.clr |=> ((lat_q & $past(wdata)) == '0) &&
                 ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata))));

  p_tog_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.tog |=> ((lat_q ^ $past(lat_q)) == $past(wdata)));

  p_hold_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wstb.dout || wstb.set || wstb.clr || wstb.tog) |=> $stable(lat_q));

  p_hold_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wstb.dir |=> $stable(dir_q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] sync_o
);

  logic [NUM_PINS-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= '0;
          else        stg_q[0] <= pad_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];

  // settling counter used only by the check below
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R8: the first stage follows the pad one clock later
  p_sync_first_r8: assert property (@(posedge clk) disable iff (!rst_n || warm_q != 2'd3)
    stg_q[0] == $past(pad_i));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [31:0]         wr_data,
  input  logic                rd_en,
  output logic [31:0]         rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  reg_sel_e            sel;
  wr_strobe_t          wstb;
  logic [NUM_PINS-1:0] lat_q;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] pin_sync;
  logic [BUS_W-1:0]    rd_mux;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wr_en (wr_en),
    .sel   (sel),
    .wstb  (wstb)
  );

  gpio_out_latch #(.NUM_PINS(NUM_PINS)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .wstb  (wstb),
    .wdata (wr_data[NUM_PINS-1:0]),
    .lat_q (lat_q),
    .dir_q (dir_q)
  );

  gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_i  (pin_in),
    .sync_o (pin_sync)
  );

  assign pin_out = lat_q;
  assign pin_oe  = dir_q;

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_DOUT: rd_mux[NUM_PINS-1:0] = lat_q;
      SEL_DIN:  rd_mux[NUM_PINS-1:0] = pin_sync;
      SEL_DIR:  rd_mux[NUM_PINS-1:0] = dir_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R7 / R10: write-only aliases and unmapped offsets read as zero
  p_rd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (sel inside {SEL_SET, SEL_CLR, SEL_TOG, SEL_NONE}) |=> rd_data == '0);

  // R12: read data holds between reads
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb_top;

  localparam int unsigned NP   = 20;
  localparam logic [31:0] MASK = 32'h000F_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [31:0]   rd_data;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic [NP-1:0] ext_in = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  // loopback pads: outputs see their own drive, inputs see the bench
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_in);

  gpio_port_regs #(.NUM_PINS(NP), .ADDR_W(8), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= rd_en;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per completed read
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underrun", 32'h0, 32'h1);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string       t = tag_q.pop_front();
        check(t, rd_data, e);
      end
    end
  end

  // driver tasks: called at a falling edge, return at a falling edge
  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic bus_rw(logic [7:0] a, logic [31:0] d, logic [31:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic [31:0] m_out;
  logic [31:0] m_dir;

  function automatic logic [31:0] pins_exp(logic [31:0] o, logic [31:0] d, logic [NP-1:0] e);
    logic [31:0] ee;
    ee = '0;
    ee[NP-1:0] = e;
    return ((d & o) | (~d & ee)) & MASK;
  endfunction

  initial begin
    m_out = '0; m_dir = '0;
    idle(3);
    // R1 reset state
    check("R1 pin_oe at reset", 32'(pin_oe), 32'h0);
    check("R1 pin_out at reset", 32'(pin_out), 32'h0);
    check("R1 rd_data at reset", rd_data, 32'h0);
    rst_n = 1'b1;
    idle(1);
    bus_rd(8'h14, 32'h0, "R1 direction after reset");
    bus_rd(8'h00, 32'h0, "R1 output latch after reset");

    // R11 / R3 / R9: full-word write while all pins are inputs
    bus_wr(8'h00, 32'hFFFF_FFFF); m_out = MASK;
    check("R11 pins undriven after output write", 32'(pin_oe), 32'h0);
    check("R3 latch replaced", 32'(pin_out), MASK);
    bus_rd(8'h00, MASK, "R9 upper output bits read zero");

    bus_wr(8'h00, 32'hA5A5_5A5A); m_out = 32'hA5A5_5A5A & MASK;
    bus_rd(8'h00, m_out, "R3 output word replace");

    bus_wr(8'h04, 32'h0000_0F0F); m_out = (m_out | 32'h0000_0F0F) & MASK;
    bus_rd(8'h00, m_out, "R4 set bits");
    bus_wr(8'h08, 32'h00A0_00FF); m_out = m_out & ~32'h00A0_00FF;
    bus_rd(8'h00, m_out, "R5 clear bits");
    bus_wr(8'h0C, 32'hFF0F_0003); m_out = (m_out ^ 32'hFF0F_0003) & MASK;
    bus_rd(8'h00, m_out, "R6 toggle bits");
    check("R6 pin_out after toggle", 32'(pin_out), m_out);

    bus_rd(8'h04, 32'h0, "R7 set alias reads zero");
    bus_rd(8'h08, 32'h0, "R7 clear alias reads zero");
    bus_rd(8'h0C, 32'h0, "R7 toggle alias reads zero");

    // R2 direction
    bus_wr(8'h14, 32'hFFF0_00FF); m_dir = 32'hFFF0_00FF & MASK;
    check("R2 pin_oe follows direction", 32'(pin_oe), m_dir);
    bus_rd(8'h14, m_dir, "R2 direction readback with R9 mask");
    check("R11 latched value reaches enabled pins", 32'(pin_out & pin_oe), m_out & m_dir);

    // R8 input readback, mixed inputs and outputs
    ext_in = 20'hC3A5C;
    idle(2);
    bus_rd(8'h10, pins_exp(m_out, m_dir, ext_in), "R8 input word mixed pins");

    // R8 latency boundary
    begin
      automatic logic [31:0] old_v = pins_exp(m_out, m_dir, ext_in);
      ext_in = 20'h3C5A3;
      idle(1);
      bus_rd(8'h10, old_v, "R8 read on second clock sees old level");
      bus_rd(8'h10, pins_exp(m_out, m_dir, ext_in), "R8 read on third clock sees new level");
    end

    // R10 unmapped and misaligned accesses
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_wr(8'h02, 32'h0000_0000);
    bus_wr(8'hF4, 32'h0000_0000);
    bus_rd(8'h00, m_out, "R10 latch unchanged by unmapped writes");
    bus_rd(8'h14, m_dir, "R10 direction unchanged by unmapped writes");
    bus_rd(8'h18, 32'h0, "R10 unmapped read zero");
    bus_rd(8'h06, 32'h0, "R10 misaligned read zero");

    // R12 same-cycle read and write, then hold
    bus_rw(8'h00, 32'h0001_2345, m_out, "R12 read during write returns old");
    m_out = 32'h0001_2345;
    bus_rd(8'h00, m_out, "R12 following read returns new");
    idle(3);
    check("R12 rd_data holds between reads", rd_data, m_out);

    idle(2);
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule